// File: doc/BRIEF.md
# Complex Lag Autocorrelator with Sliding Window

This block takes a stream of complex samples, one per clock when the input valid is high. It multiplies each new sample by the complex conjugate of the sample that arrived a fixed number of accepted samples earlier (the lag). It then reports the sum of the most recent lag products over a window of fixed length. Typical uses are preamble or repetition detection in a receiver front end running at about one sample per clock. A threshold or peak search would follow the block.

The window sum is kept recursively. Each accepted sample adds the newest product and removes the product that falls out of the window. The removed product comes from a second circular delay line. The lagged sample comes from a circular buffer one entry longer than the lag. A synchronous clear empties both delay lines logically. After a clear, missing history counts as zero, so outputs ramp up while the lines fill. Results leave the block two clock edges after the edge that accepts the sample.

Top module: `delay_autocorr`

## Requirements
- R1: Each 16-bit input container carries a two's-complement sample in bits [9:0]. Bits [15:10] are ignored.
- R2: The delayed sample used for sample k is the sample accepted LAG samples before it. It is zero when fewer than LAG samples have been accepted since the last clear or reset.
- R3: The lag buffer has LAG+1 entries. Its write index starts at 0 and its read index starts at 1. Both indices advance once per accepted sample and return to 0 after entry LAG.
- R4: With current sample x and delayed sample d, the lag product has real part x_re*d_re + x_im*d_im and imaginary part x_im*d_re - x_re*d_im.
- R5: The output is the sum of the last WIN lag products. Products from before the last clear or reset count as zero.
- R6: The output width is 2*10+1+ceil(log2(WIN)) bits, signed. The sum is exact even for full-scale input held constant.
- R7: A sample accepted at rising edge k gives out_valid high with its result on out_re/out_im after edge k+2. At all other times out_valid is low.
- R8: While in_valid is low, no sample is accepted and no state advances. Outputs hold their last values whatever the sample inputs carry.
- R9: When clr is high at a rising edge, the block flushes samples in flight, zeroes the outputs and the window, and restarts both delay lines empty. A sample presented in that same cycle is not accepted.
- R10: rst_n is an active-low synchronous reset with the same effect as clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of history and outputs |
| in_valid | input | 1 | Sample present this cycle |
| in_re | input | 16 | Real part container, sample in bits [9:0] |
| in_im | input | 16 | Imaginary part container, sample in bits [9:0] |
| out_valid | output | 1 | New window sum on the outputs |
| out_re | output | 25 | Window sum, real part (signed) |
| out_im | output | 25 | Window sum, imaginary part (signed) |

## Verification
A constant full-scale negative input, with noise in the unused upper container bits, drives the sum to its largest magnitude. This shows whether the accumulator width is sufficient and whether the upper bits are ignored. Uniformly random samples give nonzero imaginary products, which catch a swapped sign in the conjugate, wrong lag or window indexing, and pointer wrap errors. Random gaps in valid show whether idle cycles disturb state or latency. A quarter-rate rotating phasor has a known, non-random structure and checks the ramp-up during fill. Clears and resets injected mid-stream, including one alongside a valid sample, show whether history is fully discarded.

// File: rtl/acorr_pkg.sv
// Shared constants and width helpers for the lag autocorrelator.
package acorr_pkg;
    // Container width of one sample component on the input ports.
    localparam int CONT_W = 16;
    // Significant two's-complement bits within the container.
    localparam int SMP_W  = 10;

    // Width of one complex lag product component: two SMP_W x SMP_W terms summed.
    function automatic int prod_w(input int smp_w);
        return 2 * smp_w + 1;
    endfunction

    // Width of the window accumulator that cannot overflow for a window of win products.
    function automatic int acc_w(input int smp_w, input int win);
        return prod_w(smp_w) + $clog2(win);
    endfunction
endpackage

// File: rtl/acorr_lag_line.sv
// Circular delay line of LAG+1 entries that returns the sample accepted LAG
// pushes ago. Assumes LAG >= 1 and that push is never high during a clear.
// Before LAG pushes have occurred since clear/reset, the output reads as zero.
module acorr_lag_line #(
    parameter int LAG = 8,
    parameter int W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                push,
    input  logic signed [W-1:0] din_re,
    input  logic signed [W-1:0] din_im,
    output logic signed [W-1:0] dly_re,
    output logic signed [W-1:0] dly_im
);
    localparam int DEPTH  = LAG + 1;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(LAG + 1);
    localparam logic [PTR_W-1:0]  LAST = PTR_W'(LAG);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(LAG);

    logic signed [W-1:0] mem_re [DEPTH];
    logic signed [W-1:0] mem_im [DEPTH];
    logic [PTR_W-1:0]    wr_idx;
    logic [PTR_W-1:0]    rd_idx;
    logic [FILL_W-1:0]   fill;

    // Advance write then read index on each push, wrapping after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_idx <= '0;
            rd_idx <= PTR_W'(1);
        end else if (push) begin
            wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
            rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
        end
    end

    // Count pushes up to LAG to know when the delayed entry holds real history.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill <= '0;
        end else if (push && fill != FULL) begin
            fill <= fill + 1'b1;
        end
    end

    // Store the incoming sample at the write index.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_re[wr_idx] <= din_re;
            mem_im[wr_idx] <= din_im;
        end
    end

    // Present the LAG-old sample, or zero while the line is still filling.
    always_comb begin
        dly_re = (fill == FULL) ? mem_re[rd_idx] : '0;
        dly_im = (fill == FULL) ? mem_im[rd_idx] : '0;
    end

    // R3: the read index always sits one entry ahead of the write index.
    a_r3_idx_gap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == ((wr_idx == LAST) ? '0 : wr_idx + 1'b1));

    // R3: the write index returns to entry 0 after the last entry.
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && wr_idx == LAST) |=> (wr_idx == '0));

    // R8: without a push the fill level does not move.
    a_r8_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !clr) |=> $stable(fill));
endmodule

// File: rtl/acorr_cmul.sv
// Registered conjugate product stage: p = a * conj(b), full precision.
// Assumes signed W-bit operands; the result is 2W+1 bits per component.
module acorr_cmul #(
    parameter int W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  in_v,
    input  logic signed [W-1:0]   a_re,
    input  logic signed [W-1:0]   a_im,
    input  logic signed [W-1:0]   b_re,
    input  logic signed [W-1:0]   b_im,
    output logic                  out_v,
    output logic signed [2*W:0]   p_re,
    output logic signed [2*W:0]   p_im
);
    localparam int MW = 2 * W;

    logic signed [MW-1:0] ax_re, ax_im, bx_re, bx_im;
    logic signed [MW-1:0] m_rr, m_ii, m_ir, m_ri;

    // Sign-extend operands and form the four partial products.
    always_comb begin
        ax_re = {{W{a_re[W-1]}}, a_re};
        ax_im = {{W{a_im[W-1]}}, a_im};
        bx_re = {{W{b_re[W-1]}}, b_re};
        bx_im = {{W{b_im[W-1]}}, b_im};
        m_rr  = ax_re * bx_re;
        m_ii  = ax_im * bx_im;
        m_ir  = ax_im * bx_re;
        m_ri  = ax_re * bx_im;
    end

    // Move the valid flag along; a clear drops the sample in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) out_v <= 1'b0;
        else               out_v <= in_v;
    end

    // Combine partial products into the conjugate product components.
    always_ff @(posedge clk) begin
        if (in_v) begin
            p_re <= {m_rr[MW-1], m_rr} + {m_ii[MW-1], m_ii};
            p_im <= {m_ir[MW-1], m_ir} - {m_ri[MW-1], m_ri};
        end
    end

    // R4: a zero delayed operand yields a zero product.
    a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && b_re == '0 && b_im == '0) |=> (p_re == '0 && p_im == '0));
endmodule

// File: rtl/acorr_window.sv
// Recursive sliding-window sum over the last WIN products. A circular line of
// WIN entries returns the product leaving the window; entries not yet written
// since clear/reset read as zero. Assumes WIN >= 2.
module acorr_window #(
    parameter int WIN = 16,
    parameter int PW  = 21
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               in_v,
    input  logic signed [PW-1:0]               p_re,
    input  logic signed [PW-1:0]               p_im,
    output logic                               out_v,
    output logic signed [PW+$clog2(WIN)-1:0]   sum_re,
    output logic signed [PW+$clog2(WIN)-1:0]   sum_im
);
    localparam int AW     = PW + $clog2(WIN);
    localparam int PTR_W  = $clog2(WIN);
    localparam int FILL_W = $clog2(WIN + 1);
    localparam logic [PTR_W-1:0]  LAST = PTR_W'(WIN - 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(WIN);

    logic signed [PW-1:0] hist_re [WIN];
    logic signed [PW-1:0] hist_im [WIN];
    logic [PTR_W-1:0]     idx;
    logic [FILL_W-1:0]    fill;
    logic signed [PW-1:0] old_re, old_im;
    logic signed [AW-1:0] add_re, add_im, sub_re, sub_im;

    // Pick the product leaving the window, zero while the line is filling.
    always_comb begin
        old_re = (fill == FULL) ? hist_re[idx] : '0;
        old_im = (fill == FULL) ? hist_im[idx] : '0;
        add_re = {{(AW-PW){p_re[PW-1]}}, p_re};
        add_im = {{(AW-PW){p_im[PW-1]}}, p_im};
        sub_re = {{(AW-PW){old_re[PW-1]}}, old_re};
        sub_im = {{(AW-PW){old_im[PW-1]}}, old_im};
    end

    // Update the running sums and the output valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_re <= '0;
            sum_im <= '0;
            out_v  <= 1'b0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                sum_re <= sum_re + add_re - sub_re;
                sum_im <= sum_im + add_im - sub_im;
            end
        end
    end

    // Advance the product line index and its fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx  <= '0;
            fill <= '0;
        end else if (in_v) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
            if (fill != FULL) fill <= fill + 1'b1;
        end
    end

    // Store the newest product over the one that just left.
    always_ff @(posedge clk) begin
        if (in_v) begin
            hist_re[idx] <= p_re;
            hist_im[idx] <= p_im;
        end
    end

    // R8: with no product arriving the sums stay put.
    a_r8_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_v && !clr) |=> ($stable(sum_re) && $stable(sum_im)));

    // R9: a clear leaves zero sums and no valid output.
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_re == '0 && sum_im == '0 && !out_v));
endmodule

// File: rtl/delay_autocorr.sv
// Top of the lag autocorrelator. Stage 1 captures the new sample with its
// LAG-old partner, stage 2 forms the conjugate product, stage 3 updates the
// window sum. Assumes one sample per clock at most, LAG >= 1, WIN >= 2.
module delay_autocorr #(
    parameter int LAG    = 8,
    parameter int WIN    = 16,
    parameter int CONT_W = acorr_pkg::CONT_W,
    parameter int SMP_W  = acorr_pkg::SMP_W
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          clr,
    input  logic                                          in_valid,
    input  logic [CONT_W-1:0]                             in_re,
    input  logic [CONT_W-1:0]                             in_im,
    output logic                                          out_valid,
    output logic signed [acorr_pkg::acc_w(SMP_W, WIN)-1:0] out_re,
    output logic signed [acorr_pkg::acc_w(SMP_W, WIN)-1:0] out_im
);
    localparam int PW = acorr_pkg::prod_w(SMP_W);

    logic                    accept;
    logic signed [SMP_W-1:0] x_re, x_im, d_re, d_im;
    logic signed [SMP_W-1:0] s1_x_re, s1_x_im, s1_d_re, s1_d_im;
    logic                    s1_v;
    logic                    s2_v;
    logic signed [PW-1:0]    s2_p_re, s2_p_im;
    logic                    unused_hi;

    // Extract the significant sample bits; a clear blocks acceptance.
    always_comb begin
        accept    = in_valid && !clr;
        x_re      = in_re[SMP_W-1:0];
        x_im      = in_im[SMP_W-1:0];
        unused_hi = ^{in_re[CONT_W-1:SMP_W], in_im[CONT_W-1:SMP_W]};
    end

    acorr_lag_line #(.LAG(LAG), .W(SMP_W)) lag_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(accept),
        .din_re(x_re), .din_im(x_im), .dly_re(d_re), .dly_im(d_im)
    );

    // Stage 1: hold the current sample beside its delayed partner.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) s1_v <= 1'b0;
        else               s1_v <= accept;
        if (accept) begin
            s1_x_re <= x_re;
            s1_x_im <= x_im;
            s1_d_re <= d_re;
            s1_d_im <= d_im;
        end
    end

    acorr_cmul #(.W(SMP_W)) mul_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_v(s1_v),
        .a_re(s1_x_re), .a_im(s1_x_im), .b_re(s1_d_re), .b_im(s1_d_im),
        .out_v(s2_v), .p_re(s2_p_re), .p_im(s2_p_im)
    );

    acorr_window #(.WIN(WIN), .PW(PW)) win_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_v(s2_v),
        .p_re(s2_p_re), .p_im(s2_p_im),
        .out_v(out_valid), .sum_re(out_re), .sum_im(out_im)
    );

    // R7: an accepted sample with no clear behind it shows up after two more edges.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) ##1 !clr ##1 !clr |=> out_valid);

    // R9: a clear suppresses the output valid on the next cycle.
    a_r9_no_valid_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_valid);
endmodule

// File: tb/delay_autocorr_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural model with queues, compared every cycle.
module delay_autocorr_tb_top;
    localparam int LAG = 8;
    localparam int WIN = 16;
    localparam int AW  = 2 * 10 + 1 + $clog2(WIN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic out_valid;
    logic signed [AW-1:0] out_re, out_im;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R10";

    // Model state
    int hx_re[$], hx_im[$], pq_re[$], pq_im[$];
    bit m1v = 0, m2v = 0, mov = 0;
    longint m1re = 0, m1im = 0, m2re = 0, m2im = 0, more = 0, moim = 0;

    delay_autocorr #(.LAG(LAG), .WIN(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    always #2.5 clk = ~clk;

    function automatic int smp(input logic [15:0] c);
        return int'(signed'(c[9:0]));
    endfunction

    // Reference model: full window re-sum per accepted sample, 3 register stages.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            hx_re.delete(); hx_im.delete(); pq_re.delete(); pq_im.delete();
            m1v = 0; m2v = 0; mov = 0; more = 0; moim = 0;
        end else begin
            mov = m2v;
            if (m2v) begin more = m2re; moim = m2im; end
            m2v = m1v; m2re = m1re; m2im = m1im;
            m1v = in_valid;
            if (in_valid) begin
                int xr, xi, dr, di;
                longint sr, si;
                xr = smp(in_re); xi = smp(in_im);
                hx_re.push_back(xr); hx_im.push_back(xi);
                if (hx_re.size() > LAG + 1) begin
                    void'(hx_re.pop_front()); void'(hx_im.pop_front());
                end
                dr = (hx_re.size() == LAG + 1) ? hx_re[0] : 0;
                di = (hx_im.size() == LAG + 1) ? hx_im[0] : 0;
                pq_re.push_back(xr * dr + xi * di);
                pq_im.push_back(xi * dr - xr * di);
                if (pq_re.size() > WIN) begin
                    void'(pq_re.pop_front()); void'(pq_im.pop_front());
                end
                sr = 0; si = 0;
                foreach (pq_re[i]) begin sr += pq_re[i]; si += pq_im[i]; end
                m1re = sr; m1im = si;
            end
        end
    end

    // Compare outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_cmp++;
            if (out_valid !== mov || longint'(out_re) != more || longint'(out_im) != moim) begin
                n_bad++;
                $display("FAIL [%s] t=%0t: actual v=%0b re=%0d im=%0d, expected v=%0b re=%0d im=%0d",
                         cur_req, $time, out_valid, out_re, out_im, mov, more, moim);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_bad++;
            $display("FAIL [R7] watchdog: actual cycles=%0d expected<=50000", cyc);
            finish_run();
        end
    end

    task automatic drive(input bit v, input int re, input int im);
        @(negedge clk);
        in_valid = v;
        in_re = {6'($urandom), 10'(re)};
        in_im = {6'($urandom), 10'(im)};
    endtask

    function automatic int rnd_smp();
        return int'($urandom_range(0, 1023)) - 512;
    endfunction

    initial begin
        // R10: outputs zero and invalid during and after reset
        cur_req = "R10";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 R6: full-scale constant with noisy upper container bits
        cur_req = "R1 R6";
        for (int k = 0; k < 40; k++) drive(1'b1, -512, -512);
        for (int k = 0; k < 30; k++) drive(1'b1, 511, -512);

        // R2 R3 R4 R5: random samples back to back, many pointer wraps
        cur_req = "R2 R3 R4 R5";
        for (int k = 0; k < 200; k++) drive(1'b1, rnd_smp(), rnd_smp());

        // R7 R8: random valid gaps with junk on idle inputs
        cur_req = "R7 R8";
        for (int k = 0; k < 300; k++) drive(($urandom_range(0, 1) == 1), rnd_smp(), rnd_smp());
        for (int k = 0; k < 8; k++) drive(1'b0, rnd_smp(), rnd_smp());

        // R4 R5: quarter-rate phasor after a clear, covers fill ramp
        cur_req = "R4 R5 R9";
        @(negedge clk); clr = 1'b1; in_valid = 1'b0;
        @(negedge clk); clr = 1'b0;
        for (int k = 0; k < 64; k++) begin
            case (k % 4)
                0: drive(1'b1, 300, 0);
                1: drive(1'b1, 0, 300);
                2: drive(1'b1, -300, 0);
                default: drive(1'b1, 0, -300);
            endcase
        end

        // R9: clear while a valid sample is presented mid-stream
        cur_req = "R9";
        for (int k = 0; k < 20; k++) drive(1'b1, rnd_smp(), rnd_smp());
        @(negedge clk); clr = 1'b1; in_valid = 1'b1; in_re = 16'h0155; in_im = 16'h02AA;
        @(negedge clk); clr = 1'b0;
        for (int k = 0; k < 60; k++) drive(1'b1, rnd_smp(), rnd_smp());

        // R10: reset mid-stream then resume
        cur_req = "R10";
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 40; k++) drive(1'b1, rnd_smp(), rnd_smp());
        for (int k = 0; k < 6; k++) drive(1'b0, 0, 0);

        finish_run();
    end
endmodule